// File: doc/BRIEF.md
# Number-Indexed Multiprocessor Interrupt Controller

This block collects a vector of level-sensitive interrupt sources and drives one interrupt line to each of up to four processors. Software never read-modify-writes an enable bitmap. To turn a shared source on or off, it writes the source's number to a set strobe or a clear strobe. Each processor has its own register window. In that window it masks or unmasks the private low-numbered sources with the same number-write scheme, sets a blocking threshold, reads a bitmap of its pending private sources, and reads an acknowledge register that names the lowest pending source.

Every source also has a routing word with one bit per processor. A source reaches processor c only if all of the following hold: the controller is on, the source is active, the source is enabled (shared sources) or unmasked for c (private sources), and bit c of its routing word is set. The interrupt lines are combinational functions of the source inputs and the stored state, so a line drops in the same cycle its source is withdrawn.

Top module: `numbered_intc`

## Requirements
- R1: After reset the controller is off, every shared source is disabled, every private source is masked on every processor, all routing words are zero, every threshold reads 0xF, all interrupt lines are low, and every acknowledge register reads 0x3FF.
- R2: The global control word at address 0x0000 holds an on bit in bit 0 that is written and read back. Bits [11:2] read the number of implemented sources. While the on bit is 0, no interrupt line is high.
- R3: Writing a source number n with 32 <= n < N_SRC to address 0x0030 enables shared source n. Writing it to 0x0034 disables that source.
- R4: A write to 0x0030 or 0x0034 whose value is below 32 or at least N_SRC changes no enable state. This includes values whose low bits alias a real source.
- R5: In a processor's window, writing n < 32 to offset 0x4C unmasks private source n for that processor only, and writing it to offset 0x48 masks it. A value of 32 or more written to either offset is ignored.
- R6: The routing word of source n is at 0x0100 + 4n. Bit c routes the source to processor c. Only the low N_CPU bits are stored, and the other bits read as zero.
- R7: Offset 0x10 of a processor's window reads a bitmap whose bit n (n < 32) is 1 when private source n is pending for that processor. Shared sources do not appear in it.
- R8: Offset 0x40 of a processor's window is a 4-bit threshold that is written and read back. A nonzero value holds that processor's interrupt line low and makes its acknowledge read 0x3FF. A value of 0 lets everything through.
- R9: Offset 0x44 of a processor's window reads the lowest-numbered pending source for that processor in bits [9:0], with the upper bits zero. It reads 0x3FF when nothing is pending or the threshold is nonzero. Reading it has no side effect.
- R10: The interrupt line of processor c is high exactly when some source is pending for c and the threshold of c is 0. It follows a source input combinationally, in the same cycle.
- R11: Processor c's window starts at 0x8000 + 0x100*c. A write to one window affects only that processor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 16 | Register byte address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_in | input | N_SRC | Level-sensitive source inputs, bit n is source n |
| irq_out | output | N_CPU | Interrupt line per processor |

## Verification
The assertions take the register bus to be a single-cycle write strobe with the address and data stable in that cycle. They also take the source inputs to be synchronous to `clk`. Under that assumption, comparing a source input with the same-cycle state of the lines is meaningful. The bench drives the strobe, the address, the data and the source levels only on falling edges, and it holds each source level across a write. It then samples the lines and the combinational read data a moment after each change, never at a rising edge.

// File: rtl/nintc_pkg.sv
package nintc_pkg;
   localparam int          NUM_W    = 10;
   localparam logic [9:0]  NUM_NONE = 10'h3FF;
   localparam int          PRIV_N   = 32;
   localparam int          THR_W    = 4;
   localparam logic [3:0]  THR_RST  = 4'hF;

   localparam logic [14:0] G_CTRL   = 15'h0000;
   localparam logic [14:0] G_SET    = 15'h0030;
   localparam logic [14:0] G_CLR    = 15'h0034;
   localparam logic [14:0] G_ROUTE  = 15'h0100;

   localparam logic [7:0]  C_CAUSE  = 8'h10;
   localparam logic [7:0]  C_THR    = 8'h40;
   localparam logic [7:0]  C_ACK    = 8'h44;
   localparam logic [7:0]  C_MASK   = 8'h48;
   localparam logic [7:0]  C_UNMASK = 8'h4C;
endpackage

// File: rtl/nintc_src_regs.sv
module nintc_src_regs
   import nintc_pkg::*;
#(
   parameter int N_SRC = 64,
   parameter int N_CPU = 4,
   localparam int IDX_W = $clog2(N_SRC)
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         set_stb,
   input  logic                         clr_stb,
   input  logic [31:0]                  wdata,
   input  logic                         route_we,
   input  logic [IDX_W-1:0]             route_idx,
   output logic [N_SRC-1:0]             en,
   output logic [N_SRC-1:0][N_CPU-1:0]  route
);

   for (genvar n = 0; n < N_SRC; n++) begin : g_src
      if (n < PRIV_N) begin : g_priv
         // private sources are gated by the per-processor masks instead
         assign en[n] = 1'b1;
      end else begin : g_shared
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               en[n] <= 1'b0;
            else if (set_stb && wdata == 32'(n))
               en[n] <= 1'b1;
            else if (clr_stb && wdata == 32'(n))
               en[n] <= 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            route[n] <= '0;
         else if (route_we && route_idx == IDX_W'(n))
            route[n] <= wdata[N_CPU-1:0];
      end
   end

   // R4: out-of-range numbers leave every enable untouched
   a_r4_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_stb || clr_stb) && wdata >= 32'(N_SRC)) |=> $stable(en));
   // R4: private numbers on the shared strobes are ignored
   a_r4_priv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_stb || clr_stb) && wdata < 32'(PRIV_N)) |=> $stable(en));
   // R3: a valid set strobe leaves the named source enabled
   a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb && wdata >= 32'(PRIV_N) && wdata < 32'(N_SRC))
      |=> en[$past(wdata[IDX_W-1:0])]);
   // R3: a valid clear strobe leaves the named source disabled
   a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && wdata >= 32'(PRIV_N) && wdata < 32'(N_SRC))
      |=> !en[$past(wdata[IDX_W-1:0])]);

endmodule

// File: rtl/nintc_cpu_port.sv
module nintc_cpu_port
   import nintc_pkg::*;
#(
   parameter int N_SRC = 64
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_on,
   input  logic [N_SRC-1:0]  src_in,
   input  logic [N_SRC-1:0]  en,
   input  logic [N_SRC-1:0]  route_col,
   input  logic              mask_stb,
   input  logic              unmask_stb,
   input  logic              thr_we,
   input  logic [31:0]       wdata,
   output logic [31:0]       cause,
   output logic [THR_W-1:0]  thr,
   output logic [NUM_W-1:0]  ack,
   output logic              irq
);

   logic [PRIV_N-1:0] pmask;
   logic [N_SRC-1:0]  allow;
   logic [N_SRC-1:0]  pend;
   logic [NUM_W-1:0]  lowest;
   logic              open_gate;

   for (genvar n = 0; n < PRIV_N; n++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pmask[n] <= 1'b1;
         else if (mask_stb && wdata == 32'(n))
            pmask[n] <= 1'b1;
         else if (unmask_stb && wdata == 32'(n))
            pmask[n] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         thr <= THR_RST;
      else if (thr_we)
         thr <= wdata[THR_W-1:0];
   end

   assign allow     = {{(N_SRC-PRIV_N){1'b1}}, ~pmask};
   assign pend      = src_in & en & route_col & allow & {N_SRC{ctrl_on}};
   assign open_gate = (thr == '0);

   always_comb begin
      lowest = NUM_NONE;
      for (int i = N_SRC-1; i >= 0; i--)
         if (pend[i]) lowest = NUM_W'(i);
   end

   assign cause = pend[PRIV_N-1:0];
   assign irq   = open_gate && (|pend);
   assign ack   = open_gate ? lowest : NUM_NONE;

   // R9: a raised line always has a source to acknowledge
   a_r9_irq_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ack != NUM_NONE));
   // R9: the acknowledged number is a live, routed source
   a_r9_ack_live: assert property (@(posedge clk) disable iff (!rst_n)
      (ack != NUM_NONE) |-> (ack < NUM_W'(N_SRC) && src_in[ack] && route_col[ack]));
   // R5: numbers of 32 or more never touch the private masks
   a_r5_wide_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_stb || unmask_stb) && wdata >= 32'(PRIV_N)) |=> $stable(pmask));
   // R10: no line without an active input
   a_r10_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|src_in));

endmodule

// File: rtl/numbered_intc.sv
module numbered_intc
   import nintc_pkg::*;
#(
   parameter int N_SRC = 64,
   parameter int N_CPU = 4,
   localparam int IDX_W = $clog2(N_SRC)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [N_SRC-1:0]  src_in,
   output logic [N_CPU-1:0]  irq_out
);

   if (N_CPU < 1 || N_CPU > 4) begin : g_bad_cpu
      $error("numbered_intc: N_CPU must be 1..4");
   end
   if (N_SRC <= PRIV_N || N_SRC > 1023) begin : g_bad_src
      $error("numbered_intc: N_SRC must be 33..1023");
   end

   logic                        ctrl_on;
   logic                        in_glob, in_cpu;
   logic [14:0]                 goff, roff;
   logic [12:0]                 ridx_w;
   logic                        route_hit;
   logic [1:0]                  csel;
   logic [7:0]                  coff;
   logic [N_SRC-1:0]            en;
   logic [N_SRC-1:0][N_CPU-1:0] route;
   logic [N_CPU-1:0][31:0]      cause_v;
   logic [N_CPU-1:0][THR_W-1:0] thr_v;
   logic [N_CPU-1:0][NUM_W-1:0] ack_v;

   assign in_glob   = !addr[15];
   assign in_cpu    = addr[15] && (addr[14:10] == '0);
   assign goff      = addr[14:0];
   assign csel      = addr[9:8];
   assign coff      = addr[7:0];
   assign roff      = goff - G_ROUTE;
   assign ridx_w    = roff[14:2];
   assign route_hit = in_glob && (goff >= G_ROUTE) && (roff[1:0] == 2'b00)
                      && (ridx_w < 13'(N_SRC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_on <= 1'b0;
      else if (wr_en && in_glob && goff == G_CTRL)
         ctrl_on <= wdata[0];
   end

   nintc_src_regs #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_stb   (wr_en && in_glob && goff == G_SET),
      .clr_stb   (wr_en && in_glob && goff == G_CLR),
      .wdata     (wdata),
      .route_we  (wr_en && route_hit),
      .route_idx (ridx_w[IDX_W-1:0]),
      .en        (en),
      .route     (route)
   );

   for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      logic [N_SRC-1:0] col;
      logic             sel;
      for (genvar n = 0; n < N_SRC; n++) begin : g_col
         assign col[n] = route[n][c];
      end
      assign sel = wr_en && in_cpu && (csel == 2'(c));

      nintc_cpu_port #(.N_SRC(N_SRC)) u_port (
         .clk        (clk),
         .rst_n      (rst_n),
         .ctrl_on    (ctrl_on),
         .src_in     (src_in),
         .en         (en),
         .route_col  (col),
         .mask_stb   (sel && coff == C_MASK),
         .unmask_stb (sel && coff == C_UNMASK),
         .thr_we     (sel && coff == C_THR),
         .wdata      (wdata),
         .cause      (cause_v[c]),
         .thr        (thr_v[c]),
         .ack        (ack_v[c]),
         .irq        (irq_out[c])
      );
   end

   always_comb begin
      rdata = '0;
      if (in_glob) begin
         if (goff == G_CTRL)
            rdata = {20'b0, NUM_W'(N_SRC), 1'b0, ctrl_on};
         else if (route_hit)
            rdata = 32'(route[ridx_w[IDX_W-1:0]]);
      end else if (in_cpu && 32'(csel) < 32'(N_CPU)) begin
         case (coff)
            C_CAUSE: rdata = cause_v[csel];
            C_THR:   rdata = 32'(thr_v[csel]);
            C_ACK:   rdata = 32'(ack_v[csel]);
            default: rdata = '0;
         endcase
      end
   end

   // R2: with the controller off no line is raised
   a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_on |-> (irq_out == '0));
   // R1: the control bit comes out of reset cleared
   a_r1_ctrl_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !ctrl_on);

endmodule

// File: tb/numbered_intc_bench.sv
`timescale 1ns/1ps
module numbered_intc_bench;
   localparam int N_SRC = 64;
   localparam int N_CPU = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [15:0]       addr = '0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic [N_SRC-1:0]  src_in = '0;
   logic [N_CPU-1:0]  irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   numbered_intc #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_numbered_intc (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .src_in(src_in), .irq_out(irq_out));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic set_src(input int n, input logic v);
      @(negedge clk);
      src_in[n] = v;
      #1;
   endtask

   function automatic logic [15:0] cpu_a(input int c, input logic [7:0] off);
      return 16'h8000 + 16'(c * 16'h100) + 16'(off);
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(16'h0000, d);  check("R1 ctrl reset / R2 count", d, 32'h100);
      check("R1 lines low", 32'(irq_out), 32'h0);
      rd(cpu_a(0, 8'h44), d); check("R1 ack empty", d, 32'h3FF);
      rd(cpu_a(3, 8'h40), d); check("R1 threshold reset (R11 window 3)", d, 32'hF);
      rd(16'h01A0, d); check("R1 route reset", d, 32'h0);
   endtask

   task automatic t_ctrl_on();
      logic [31:0] d;
      wr(16'h0000, 32'h1);
      rd(16'h0000, d); check("R2 on bit readback", d, 32'h101);
   endtask

   task automatic t_shared();
      logic [31:0] d;
      wr(16'h01A0, 32'h0000_FFF2);
      rd(16'h01A0, d); check("R6 route low bits only", d, 32'h2);
      wr(cpu_a(1, 8'h40), 32'h0);
      set_src(40, 1'b1);
      check("R3 disabled source quiet", 32'(irq_out), 32'h0);
      wr(16'h0030, 32'd104);
      check("R4 aliasing number ignored", 32'(irq_out), 32'h0);
      wr(16'h0030, 32'd40);
      check("R3 set enables / R10 line", 32'(irq_out), 32'h2);
      rd(cpu_a(1, 8'h44), d); check("R9 ack cpu1 / R11", d, 32'd40);
      rd(cpu_a(0, 8'h44), d); check("R11 other window untouched", d, 32'h3FF);
      rd(cpu_a(1, 8'h10), d); check("R7 shared not in cause", d, 32'h0);
      set_src(40, 1'b0);
      check("R10 same-cycle drop", 32'(irq_out), 32'h0);
      set_src(40, 1'b1);
      check("R10 same-cycle rise", 32'(irq_out), 32'h2);
      wr(16'h0034, 32'd40);
      check("R3 clear disables", 32'(irq_out), 32'h0);
      wr(16'h0030, 32'd40);
      check("R3 re-enable", 32'(irq_out), 32'h2);
   endtask

   task automatic t_private();
      logic [31:0] d;
      wr(16'h010C, 32'h5);
      wr(cpu_a(0, 8'h40), 32'h0);
      wr(cpu_a(2, 8'h40), 32'h0);
      set_src(3, 1'b1);
      check("R5 masked private quiet", 32'(irq_out), 32'h2);
      wr(cpu_a(0, 8'h4C), 32'd3);
      check("R5 unmask one cpu", 32'(irq_out), 32'h3);
      rd(cpu_a(0, 8'h10), d); check("R7 cause cpu0", d, 32'h8);
      rd(cpu_a(2, 8'h10), d); check("R5 cpu2 still masked", d, 32'h0);
      wr(16'h0034, 32'd3);
      check("R4 private on clear strobe ignored", 32'(irq_out), 32'h3);
      wr(cpu_a(0, 8'h48), 32'd35);
      check("R5 wide mask number ignored", 32'(irq_out), 32'h3);
      rd(cpu_a(0, 8'h44), d); check("R9 ack private", d, 32'd3);
      wr(16'h01A0, 32'h3);
      rd(cpu_a(0, 8'h44), d); check("R9 lowest wins", d, 32'd3);
      set_src(3, 1'b0);
      rd(cpu_a(0, 8'h44), d); check("R9 next pending", d, 32'd40);
      set_src(3, 1'b1);
      wr(cpu_a(0, 8'h48), 32'd3);
      rd(cpu_a(0, 8'h10), d); check("R5 mask again", d, 32'h0);
      rd(cpu_a(0, 8'h44), d); check("R9 ack after mask", d, 32'd40);
   endtask

   task automatic t_threshold();
      logic [31:0] d;
      wr(cpu_a(0, 8'h40), 32'h2);
      rd(cpu_a(0, 8'h40), d); check("R8 threshold readback", d, 32'h2);
      check("R8 nonzero blocks cpu0", 32'(irq_out), 32'h2);
      rd(cpu_a(0, 8'h44), d); check("R8 ack blocked", d, 32'h3FF);
      wr(cpu_a(0, 8'h40), 32'h0);
      check("R8 zero opens", 32'(irq_out), 32'h3);
   endtask

   task automatic t_off();
      logic [31:0] d;
      wr(16'h0000, 32'h0);
      check("R2 off drops lines", 32'(irq_out), 32'h0);
      rd(16'h0000, d); check("R2 off readback", d, 32'h100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl_on();
      t_shared();
      t_private();
      t_threshold();
      t_off();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule